// File: doc/BRIEF.md
# RGB LED PWM Blink Sequencer

This block turns per-channel lighting settings into on/off gate enables for the red, green and blue LED drivers. A shared time base is stepped by a fixed-rate `tick` input. In normal operation the three channels take turns. The PWM period splits into three equal phases, red then green then blue, and within its own phase a channel conducts for as many ticks as its present brightness level. In flash operation the three channels share a single phase, which gives three times the average drive at the same level.

A slower blink envelope sits on top of the PWM. A 7-bit position counter walks through 128 steps of a blink cycle whose length is picked by a 2-bit select. Each channel has a start position and a stop position. Between them its target level is its duty setting, and outside them the target is zero. A per-channel slope setting sets how fast the actual level moves toward the target, one count at a time. Two encodings are reserved: a start equal to the stop with both zero means steady on, and a nonzero start equal to the stop means steady off. A master start bit and a hold input from the mode controller can force everything dark. A PWM-enable bit bypasses the generator for direct per-channel control. An external gate pin can mask chosen channels.

Top module: `rgb_blink_seq`

## Requirements
- R1: While `master_start` is 0 or `mode_hold` is 1, all outputs are 0 from the next clock, and the PWM counters, blink position and levels are held at zero.
- R2: In normal mode (`flash_mode`=0, `pwm_enable`=1) the PWM period is 3*PHASE_TICKS ticks. Phase 0 belongs to red (bit 0), phase 1 to green (bit 1) and phase 2 to blue (bit 2). A channel is on during the first L ticks of its phase, where L is its level. No two outputs are on at once.
- R3: In flash mode (`flash_mode`=1) every channel is on during the first L ticks of each PHASE_TICKS-tick period, independent of the phase.
- R4: A channel whose start and stop fields are both 0 has a constant target equal to its 4-bit duty field and does not blink.
- R5: A channel whose start field equals its stop field with a nonzero value stays off.
- R6: The blink position advances by 1 (mod 128) every BLINK_BASE_TICKS << `blink_sel` ticks. For start < stop the target is the duty when start <= position < stop. For start > stop the window wraps: position >= start or position < stop. Outside the window the target is 0.
- R7: With slope 0 the level takes the target value at once. With slope s > 0 the level moves one count toward the target every s*SLOPE_UNIT_TICKS ticks.
- R8: With `pwm_enable`=0 each output equals its `chan_enable` bit, still subject to R1 and R10.
- R9: A channel whose `chan_enable` bit is 0 stays off in PWM modes.
- R10: A channel whose `ext_gate_sel` bit is 1 is additionally ANDed with the `ext_gate` pin.
- R11: While `tick` is 0 the time base and levels do not advance, so the outputs stay constant.
- R12: Outputs are registered: they reflect the state of the previous clock, and they are 0 in reset.
- Field packing: channel c uses `duty_all[4c+3:4c]`, `slope_all[4c+3:4c]`, `on_all[7c+6:7c]` and `off_all[7c+6:7c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Time-base step strobe |
| mode_hold | input | 1 | Blocking request from the mode controller |
| master_start | input | 1 | Master enable of the whole function |
| pwm_enable | input | 1 | 1: internal PWM/blink, 0: direct enables |
| flash_mode | input | 1 | 1: single shared phase |
| blink_sel | input | 2 | Blink cycle length select (base << sel) |
| ext_gate | input | 1 | External on/off or PWM gate pin |
| ext_gate_sel | input | 3 | Per-channel use of the external gate |
| chan_enable | input | 3 | Per-channel enable |
| duty_all | input | 12 | Packed 4-bit duty per channel |
| slope_all | input | 12 | Packed 4-bit slope per channel |
| on_all | input | 21 | Packed 7-bit blink start position per channel |
| off_all | input | 21 | Packed 7-bit blink stop position per channel |
| led_on | output | 3 | Gate enables: bit 0 red, bit 1 green, bit 2 blue |

## Verification
Each output bit shows the counter and level state one clock after that state forms. A level follows its target one clock after the position changes. A settings change while the block is released first shows at the ports two clocks later. The bench therefore does not compare single samples. It counts on-samples over whole PWM periods, 3*PHASE_TICKS ticks in normal mode and PHASE_TICKS in flash mode, or over whole blink cycles. It counts only after a full settling period, when the waveform is periodic and a window of one period gives an exact total. The slope ramp is the one exception: there the periods are counted from the first clock after release, where the level during period k is exactly min(k, 15).

// File: rtl/rgb_seq_pkg.sv
// Shared constants and helpers for the RGB blink sequencer.
// Assumes three channels, 4-bit duty/slope and 7-bit blink positions.
package rgb_seq_pkg;
    localparam int NCH    = 3;
    localparam int LVL_W  = 4;
    localparam int POS_W  = 7;

    // True when a blink position falls inside a channel's lit window.
    function automatic logic win_lit(input logic [POS_W-1:0] start_p,
                                     input logic [POS_W-1:0] stop_p,
                                     input logic [POS_W-1:0] pos);
        logic lit;
        if (start_p == stop_p)
            lit = (start_p == '0);          // both zero: steady on; else steady off
        else if (start_p < stop_p)
            lit = (pos >= start_p) && (pos < stop_p);
        else
            lit = (pos >= start_p) || (pos < stop_p);
        return lit;
    endfunction
endpackage

// File: rtl/rgb_timebase.sv
// Shared time base: PWM sub-tick counter, phase index (0..2) and the
// 7-bit blink position. Advances only on tick; cleared while blocked.
// Assumes PHASE_TICKS >= 16 so that every 4-bit level fits in a phase.
module rgb_timebase #(
    parameter int PHASE_TICKS      = 16,
    parameter int BLINK_BASE_TICKS = 1024
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               tick,
    input  logic                               block,
    input  logic [1:0]                         blink_sel,
    output logic [$clog2(PHASE_TICKS)-1:0]     sub,
    output logic [1:0]                         phase,
    output logic [rgb_seq_pkg::POS_W-1:0]      pos
);
    localparam int SUB_W  = $clog2(PHASE_TICKS);
    localparam int STEP_W = $clog2(BLINK_BASE_TICKS * 8 + 1);

    logic [STEP_W-1:0] step_cnt;
    logic [STEP_W-1:0] step_lim;

    // Ticks per blink position for the selected cycle length.
    always_comb step_lim = STEP_W'(BLINK_BASE_TICKS) << blink_sel;

    // Step the PWM counters and the blink position on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || block) begin
            sub      <= '0;
            phase    <= '0;
            step_cnt <= '0;
            pos      <= '0;
        end else if (tick) begin
            if (sub == SUB_W'(PHASE_TICKS - 1)) begin
                sub   <= '0;
                phase <= (phase == 2'd2) ? 2'd0 : phase + 2'd1;
            end else begin
                sub <= sub + SUB_W'(1);
            end
            if (step_cnt >= step_lim - STEP_W'(1)) begin
                step_cnt <= '0;
                pos      <= pos + 7'd1;
            end else begin
                step_cnt <= step_cnt + STEP_W'(1);
            end
        end
    end

    // R6
    // pos_step_chk: the blink position moves by at most one per clock
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !block |=> (pos == $past(pos)) || (pos == $past(pos) + 7'd1));

    // R11
    // freeze_chk: without a tick the time base holds still
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !block) |=> ($stable(pos) && $stable(sub) && $stable(phase)));

    // R2
    // phase_range_chk: the phase index never leaves 0..2
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'd3);
endmodule

// File: rtl/rgb_envelope.sv
// One channel's brightness envelope. Derives the target level from the
// blink window and duty, then moves the level toward it: at once for
// slope 0, else one count per slope*SLOPE_UNIT_TICKS ticks.
// Assumes pos comes from the shared time base and is zero while blocked.
module rgb_envelope #(
    parameter int SLOPE_UNIT_TICKS = 256
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              tick,
    input  logic                              block,
    input  logic [rgb_seq_pkg::POS_W-1:0]     pos,
    input  logic [rgb_seq_pkg::POS_W-1:0]     start_p,
    input  logic [rgb_seq_pkg::POS_W-1:0]     stop_p,
    input  logic [rgb_seq_pkg::LVL_W-1:0]     duty,
    input  logic [rgb_seq_pkg::LVL_W-1:0]     slope,
    output logic [rgb_seq_pkg::LVL_W-1:0]     level
);
    import rgb_seq_pkg::*;
    localparam int SC_W = $clog2(SLOPE_UNIT_TICKS * 15 + 1);

    logic [LVL_W-1:0] target;
    logic [SC_W-1:0]  interval;
    logic [SC_W-1:0]  slope_cnt;

    // Target level: duty inside the lit window, zero outside.
    always_comb target = win_lit(start_p, stop_p, pos) ? duty : '0;

    // Ticks between ramp steps for the current slope setting.
    always_comb interval = SC_W'(slope) * SC_W'(SLOPE_UNIT_TICKS);

    // Move the level toward the target at the configured rate.
    always_ff @(posedge clk) begin
        if (!rst_n || block) begin
            level     <= '0;
            slope_cnt <= '0;
        end else if (slope == '0) begin
            level     <= target;
            slope_cnt <= '0;
        end else if (tick) begin
            if (slope_cnt >= interval - SC_W'(1)) begin
                slope_cnt <= '0;
                if (level < target)      level <= level + LVL_W'(1);
                else if (level > target) level <= level - LVL_W'(1);
            end else begin
                slope_cnt <= slope_cnt + SC_W'(1);
            end
        end
    end

    // R7
    // ramp_step_chk: with a nonzero slope the level changes by at most one
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slope != '0 && !block) |=>
        (level == $past(level)) || (level == $past(level) + 4'd1) ||
        (level == $past(level) - 4'd1));

    // R1
    // hold_zero_chk: a blocked channel has no level
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        block |=> (level == '0));
endmodule

// File: rtl/rgb_blink_seq.sv
// RGB LED PWM blink sequencer top. Combines the shared time base with
// three channel envelopes, picks normal (three-phase) or flash (single
// phase) PWM, direct enable mode, external gating and the master block,
// and registers the three gate enables.
// Assumes tick is a single-cycle strobe at a fixed rate.
module rgb_blink_seq #(
    parameter int PHASE_TICKS      = 16,
    parameter int BLINK_BASE_TICKS = 1024,
    parameter int SLOPE_UNIT_TICKS = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        mode_hold,
    input  logic        master_start,
    input  logic        pwm_enable,
    input  logic        flash_mode,
    input  logic [1:0]  blink_sel,
    input  logic        ext_gate,
    input  logic [2:0]  ext_gate_sel,
    input  logic [2:0]  chan_enable,
    input  logic [11:0] duty_all,
    input  logic [11:0] slope_all,
    input  logic [20:0] on_all,
    input  logic [20:0] off_all,
    output logic [2:0]  led_on
);
    import rgb_seq_pkg::*;
    localparam int SUB_W = $clog2(PHASE_TICKS);

    logic                  block;
    logic [SUB_W-1:0]      sub;
    logic [1:0]            phase;
    logic [POS_W-1:0]      pos;
    logic [LVL_W-1:0]      level [NCH];
    logic [NCH-1:0]        pwm_hit;
    logic [NCH-1:0]        led_next;

    // Master block: start bit low or mode-controller hold.
    always_comb block = !master_start || mode_hold;

    rgb_timebase #(
        .PHASE_TICKS      (PHASE_TICKS),
        .BLINK_BASE_TICKS (BLINK_BASE_TICKS)
    ) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .block     (block),
        .blink_sel (blink_sel),
        .sub       (sub),
        .phase     (phase),
        .pos       (pos)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        rgb_envelope #(.SLOPE_UNIT_TICKS(SLOPE_UNIT_TICKS)) u_env (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .block   (block),
            .pos     (pos),
            .start_p (on_all[POS_W*c +: POS_W]),
            .stop_p  (off_all[POS_W*c +: POS_W]),
            .duty    (duty_all[LVL_W*c +: LVL_W]),
            .slope   (slope_all[LVL_W*c +: LVL_W]),
            .level   (level[c])
        );

        // PWM compare: own phase in normal mode, every phase in flash mode.
        always_comb pwm_hit[c] = (flash_mode || (phase == 2'(c))) &&
                                 (32'(sub) < 32'(level[c]));

        // Final gate: block, direct/PWM choice, enable and external pin.
        always_comb led_next[c] = !block && chan_enable[c] &&
                                  (!ext_gate_sel[c] || ext_gate) &&
                                  (!pwm_enable || pwm_hit[c]);
    end

    // Register the gate enables.
    always_ff @(posedge clk) begin
        if (!rst_n) led_on <= '0;
        else        led_on <= led_next;
    end

    // R2
    // one_phase_chk: in normal PWM mode at most one channel conducts
    one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_enable && !flash_mode) |-> $onehot0(led_next));

    // R1
    // blocked_off_chk: a blocked sequencer drives nothing next cycle
    blocked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        block |=> (led_on == 3'b000));

    // R10
    // ext_gate_chk: a gated channel stays dark while the pin is low
    ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_gate |=> ((led_on & $past(ext_gate_sel)) == 3'b000));
endmodule

// File: tb/tb_rgb_blink_seq.sv
module tb_rgb_blink_seq;
    localparam int PT = 16;
    localparam int BB = 48;
    localparam int SU = 48;
    localparam int PER = 3 * PT;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        tick = 1;
    logic        mode_hold = 1;
    logic        master_start = 1;
    logic        pwm_enable = 1;
    logic        flash_mode = 0;
    logic [1:0]  blink_sel = 0;
    logic        ext_gate = 1;
    logic [2:0]  ext_gate_sel = 0;
    logic [2:0]  chan_enable = 3'b111;
    logic [11:0] duty_all = 0;
    logic [11:0] slope_all = 0;
    logic [20:0] on_all = 0;
    logic [20:0] off_all = 0;
    logic [2:0]  led_on;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    rgb_blink_seq #(.PHASE_TICKS(PT), .BLINK_BASE_TICKS(BB), .SLOPE_UNIT_TICKS(SU)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_hold(mode_hold),
        .master_start(master_start), .pwm_enable(pwm_enable), .flash_mode(flash_mode),
        .blink_sel(blink_sel), .ext_gate(ext_gate), .ext_gate_sel(ext_gate_sel),
        .chan_enable(chan_enable), .duty_all(duty_all), .slope_all(slope_all),
        .on_all(on_all), .off_all(off_all), .led_on(led_on));

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected on-ticks of a channel over whole periods.
    function automatic int exp_pwm(input int lvl, input int periods);
        return lvl * periods;
    endfunction

    function automatic int win_len(input int s, input int e);
        if (s == e) return (s == 0) ? 128 : 0;
        if (s < e) return e - s;
        return 128 - s + e;
    endfunction

    task automatic set_ch(input int c, input int d, input int sl, input int s, input int e);
        duty_all[4*c +: 4]  = 4'(d);
        slope_all[4*c +: 4] = 4'(sl);
        on_all[7*c +: 7]    = 7'(s);
        off_all[7*c +: 7]   = 7'(e);
    endtask

    // Hold briefly, then release at a falling edge.
    task automatic restart();
        @(negedge clk); mode_hold = 1;
        @(negedge clk); @(negedge clk);
        mode_hold = 0;
    endtask

    task automatic count_win(input int n, output int c0, output int c1, output int c2);
        c0 = 0; c1 = 0; c2 = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            c0 += int'(led_on[0]); c1 += int'(led_on[1]); c2 += int'(led_on[2]);
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int a, b, c;
        logic [2:0] snap;
        void'($urandom(32'd1234));
        // R12 reset state
        repeat (3) @(negedge clk);
        chk("R12 reset", int'(led_on), 0);
        rst_n = 1;

        // R4 steady on, R2 normal mode counts
        set_ch(0, 15, 0, 0, 0); set_ch(1, 7, 0, 0, 0); set_ch(2, 0, 0, 0, 0);
        restart();
        count_win(PER, a, b, c);
        count_win(2 * PER, a, b, c);
        chk("R2/R4 red", a, exp_pwm(15, 2));
        chk("R2/R4 green", b, exp_pwm(7, 2));
        chk("R2 blue zero duty", c, 0);

        // R1 master start low
        master_start = 0;
        count_win(PER, a, b, c);
        chk("R1 start low", a + b + c, 0);
        master_start = 1;

        // R7 slope ramp: level in period k is min(k,15)
        set_ch(0, 15, 1, 0, 0); set_ch(1, 15, 1, 0, 0); set_ch(2, 15, 1, 0, 0);
        restart();
        for (int k = 0; k < 18; k++) begin
            count_win(PER, a, b, c);
            chk("R7 ramp red", a, (k < 15) ? k : 15);
            chk("R7 ramp green", b, (k < 15) ? k : 15);
            chk("R7 ramp blue", c, (k < 15) ? k : 15);
        end

        // R3 flash mode
        set_ch(0, 9, 0, 0, 0); set_ch(1, 4, 0, 0, 0); set_ch(2, 12, 0, 0, 0);
        flash_mode = 1;
        restart();
        count_win(PER, a, b, c);
        count_win(PT, a, b, c);
        chk("R3 flash red", a, 9);
        chk("R3 flash green", b, 4);
        chk("R3 flash blue", c, 12);
        flash_mode = 0;

        // R5, R6 blink windows with blink_sel 0 and 1
        set_ch(0, 5, 0, 10, 30); set_ch(1, 3, 0, 100, 20); set_ch(2, 9, 0, 7, 7);
        blink_sel = 0;
        restart();
        count_win(128 * BB, a, b, c);
        count_win(128 * BB, a, b, c);
        chk("R6 window red", a, win_len(10, 30) * 5);
        chk("R6 wrap green", b, win_len(100, 20) * 3);
        chk("R5 steady off blue", c, 0);
        blink_sel = 1;
        restart();
        count_win(256 * BB, a, b, c);
        count_win(256 * BB, a, b, c);
        chk("R6 sel1 red", a, win_len(10, 30) * 5 * 2);
        chk("R6 sel1 green", b, win_len(100, 20) * 3 * 2);
        blink_sel = 0;

        // R9 channel enable in PWM mode
        set_ch(0, 8, 0, 0, 0); set_ch(1, 8, 0, 0, 0); set_ch(2, 8, 0, 0, 0);
        chan_enable = 3'b010;
        restart();
        count_win(PER, a, b, c);
        count_win(PER, a, b, c);
        chk("R9 red disabled", a, 0);
        chk("R9 green enabled", b, 8);
        chk("R9 blue disabled", c, 0);
        chan_enable = 3'b111;

        // R10 external gate
        ext_gate_sel = 3'b001; ext_gate = 0;
        count_win(PER, a, b, c);
        count_win(PER, a, b, c);
        chk("R10 gate low red", a, 0);
        chk("R10 ungated green", b, 8);
        ext_gate = 1;
        count_win(2, a, b, c);
        count_win(PER, a, b, c);
        chk("R10 gate high red", a, 8);
        ext_gate_sel = 3'b000;

        // R8 direct enable mode
        pwm_enable = 0; chan_enable = 3'b101;
        count_win(2, a, b, c);
        count_win(PER, a, b, c);
        chk("R8 direct red", a, PER);
        chk("R8 direct green", b, 0);
        chk("R8 direct blue", c, PER);
        pwm_enable = 1; chan_enable = 3'b111;

        // R11 tick low freezes the outputs
        count_win(PER, a, b, c);
        tick = 0;
        count_win(2, a, b, c);
        snap = led_on;
        a = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (led_on != snap) a++;
        end
        chk("R11 frozen", a, 0);
        tick = 1;

        // R1 mode hold
        mode_hold = 1;
        count_win(PER, a, b, c);
        chk("R1 hold", a + b + c, 0);
        mode_hold = 0;

        // Random duties, normal and flash
        for (int it = 0; it < 8; it++) begin
            int d0, d1, d2, fl;
            d0 = int'($urandom_range(0, 15));
            d1 = int'($urandom_range(0, 15));
            d2 = int'($urandom_range(0, 15));
            fl = int'($urandom_range(0, 1));
            set_ch(0, d0, 0, 0, 0); set_ch(1, d1, 0, 0, 0); set_ch(2, d2, 0, 0, 0);
            flash_mode = fl[0];
            restart();
            count_win(PER, a, b, c);
            count_win(fl ? PT : PER, a, b, c);
            chk(fl ? "R3 rand red" : "R2 rand red", a, d0);
            chk(fl ? "R3 rand green" : "R2 rand green", b, d1);
            chk(fl ? "R3 rand blue" : "R2 rand blue", c, d2);
        end
        flash_mode = 0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule